// File: doc/BRIEF.md
# System clock divider and shutdown controller

This block is one byte-wide control register with the logic behind it. It makes the system clock enable by dividing a 24 MHz reference by a programmable power of two, from 1 up to 128. It steps the chip through a shutdown handshake with the power circuitry. While the register's hold bit is set, it freezes the GPIO values seen by the rest of the chip. Once power is down, it requests a full wake-up when any GPIO input falls. It also reports whether the last power-up came from battery insertion, and it gives a one-cycle clear pulse to an external real-time-clock tick counter.

Software reaches the register through a simple address/strobe port. The register answers at one special-function address, 0xBE by default. The power switch, the reset generator and the RTC counter are outside the block. Each is reached through a single signal: `shutdown_req_o` / `shutdown_done_i` for the power switch, `wake_o` for the reset generator, and `rtc_clr_o` for the RTC counter. The reset generator answers `wake_o` by resetting the chip.

Register layout: bit 7 is the shutdown request (SD), bit 6 is reserved, bit 5 is the first-power-up flag (FPU), bit 4 is the RTC clear (RC), bit 3 is the GPIO hold (HOLD), and bits 2:0 are the divider select (SEL).

Top module: `sysclk_pwr_ctrl`

## Requirements
- R1: The reset is synchronous and active low. After it, a read at 0xBE returns SD=0, HOLD=0, SEL=000 and FPU equal to `battery_insert_i` as sampled during reset. `sys_clk_en_o` is then high on every reference cycle.
- R2: With SEL=n, `sys_clk_en_o` is high for one cycle in every 2^n reference cycles.
- R3: A new SEL value takes effect only after the next `sys_clk_en_o` pulse of the current setting. The period that is running when SEL is written is never shortened.
- R4: Bits 6 and 4 always read 0. Writing 1 to either bit does not change the readback.
- R5: A write to 0xBE with bit 4 = 1 drives `rtc_clr_o` high for exactly the one cycle after the write. A write with bit 4 = 0 gives no pulse.
- R6: FPU (bit 5) is read-only. Writes leave it unchanged. A wake from shutdown clears it.
- R7: A write with bit 7 = 1 raises `shutdown_req_o` in the next cycle, and bit 7 then reads 1. A write with bit 7 = 0 made before `shutdown_done_i` arrives cancels the request.
- R8: When `shutdown_done_i` is high while a request is pending, the block enters shutdown. In shutdown, `sys_clk_en_o` stays low, `shutdown_req_o` stays high and register writes are ignored.
- R9: In shutdown, a falling edge on any bit of `gpio_i` raises `wake_o` for one cycle in the cycle after the edge. The block then leaves shutdown with SD, HOLD, SEL and FPU all 0.
- R10: While HOLD (bit 3) is 1, `gpio_o` keeps the `gpio_i` value that was present when HOLD was written. While HOLD is 0, `gpio_o` follows `gpio_i`.
- R11: A falling GPIO edge that arrives while shutdown is pending and HOLD is 1 is remembered. It raises `wake_o` one cycle after shutdown is entered.
- R12: A falling edge that arrives while shutdown is pending with HOLD at 0 is lost. Rising edges never wake the block.
- R13: Accesses to any other address leave the register unchanged, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 24 MHz reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 unless a read hits the register |
| sys_clk_en_o | output | 1 | System clock enable pulse |
| rtc_clr_o | output | 1 | One-cycle clear pulse for the RTC tick counter |
| battery_insert_i | input | 1 | High when the power-up came from battery insertion; sampled during reset |
| shutdown_req_o | output | 1 | Shutdown requested or in effect |
| shutdown_done_i | input | 1 | Power circuitry reports that shutdown is complete |
| wake_o | output | 1 | One-cycle wake request to the reset generator |
| gpio_i | input | GPIO_W | GPIO pin levels |
| gpio_o | output | GPIO_W | GPIO values as seen by the chip, frozen while held |

## Verification
The bench writes a new divider select partway through a long period. A design that switches at once would end that period early, and a design that waits too long would stretch the period after it. The bench places one falling edge in the pending window with hold set and another with hold clear. A design without the remembered edge would never wake from the first case, and a design that latches edges unconditionally would wake at once in the second. The bench also writes to the register while the block is shut down, raises a GPIO without lowering one, and writes 1 to the reserved and read-only bits. A careless decode would cancel the shutdown, wake on the rising level, or let those bits show up in the readback.

// File: rtl/sysclk_pwr_pkg.sv
package sysclk_pwr_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_PEND = 2'd1,
        PS_DOWN = 2'd2
    } pwr_state_e;

    // field positions inside the control byte
    localparam int BIT_SD   = 7;
    localparam int BIT_FPU  = 5;
    localparam int BIT_RC   = 4;
    localparam int BIT_HOLD = 3;
    localparam int DATA_W   = 8;

endpackage

// File: rtl/sysclk_div_gen.sv
module sysclk_div_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] act;
    } div_t;

    div_t             q, d;
    logic [CNT_W-1:0] last_w;
    logic             hit_w;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            last_w[i] = (i < int'(q.act));
        end
        hit_w = (q.cnt == last_w);
        en_o  = run_i && hit_w;
        d     = q;
        if (!run_i) begin
            d.cnt = '0;
            d.act = '0;
        end else if (hit_w) begin
            d.cnt = '0;
            d.act = sel_i;   // new ratio only at a period boundary
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sysclk_gpio_wake.sv
module sysclk_gpio_wake #(
    parameter int GPIO_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [GPIO_W-1:0] gpio_i,
    input  logic              hold_i,
    input  logic              arm_i,
    input  logic              clr_i,
    input  logic              down_i,
    output logic [GPIO_W-1:0] gpio_o,
    output logic              wake_req_o
);
    typedef struct packed {
        logic [GPIO_W-1:0] prev;
        logic [GPIO_W-1:0] held;
        logic              pend;
    } gw_t;

    gw_t  q, d;
    logic any_fall_w;

    always_comb begin
        any_fall_w = |(q.prev & ~gpio_i);
        gpio_o     = hold_i ? q.held : gpio_i;
        wake_req_o = down_i && (any_fall_w || q.pend);
        d          = q;
        d.prev     = gpio_i;
        d.held     = hold_i ? q.held : gpio_i;
        if (clr_i) begin
            d.pend = 1'b0;
        end else if (arm_i && any_fall_w) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sysclk_pwr_ctrl.sv
module sysclk_pwr_ctrl
    import sysclk_pwr_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hBE,
    parameter int              GPIO_W   = 8,
    parameter int              SEL_W    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              sys_clk_en_o,
    output logic              rtc_clr_o,
    input  logic              battery_insert_i,
    output logic              shutdown_req_o,
    input  logic              shutdown_done_i,
    output logic              wake_o,
    input  logic [GPIO_W-1:0] gpio_i,
    output logic [GPIO_W-1:0] gpio_o
);
    typedef struct packed {
        pwr_state_e       state;
        logic [SEL_W-1:0] sel;
        logic             hold;
        logic             fpu;
        logic             rc;
        logic             wake;
    } ctrl_t;

    ctrl_t q, d;
    logic  wr_hit_w, rd_hit_w;
    logic  hold_w, down_w, wake_req_w;

    assign wr_hit_w = wr_en_i && (addr_i == REG_ADDR);
    assign rd_hit_w = rd_en_i && (addr_i == REG_ADDR);
    assign hold_w   = q.hold;
    assign down_w   = (q.state == PS_DOWN);

    always_comb begin
        d      = q;
        d.rc   = 1'b0;
        d.wake = 1'b0;
        unique case (q.state)
            PS_RUN: begin
                if (wr_hit_w) begin
                    d.sel  = wdata_i[SEL_W-1:0];
                    d.hold = wdata_i[BIT_HOLD];
                    d.rc   = wdata_i[BIT_RC];
                    if (wdata_i[BIT_SD]) d.state = PS_PEND;
                end
            end
            PS_PEND: begin
                if (wr_hit_w) begin
                    d.sel  = wdata_i[SEL_W-1:0];
                    d.hold = wdata_i[BIT_HOLD];
                    d.rc   = wdata_i[BIT_RC];
                end
                if (shutdown_done_i) begin
                    d.state = PS_DOWN;
                end else if (wr_hit_w && !wdata_i[BIT_SD]) begin
                    d.state = PS_RUN;
                end
            end
            PS_DOWN: begin
                if (wake_req_w) begin
                    d.state = PS_RUN;
                    d.sel   = '0;
                    d.hold  = 1'b0;
                    d.fpu   = 1'b0;
                    d.wake  = 1'b1;
                end
            end
            default: d.state = PS_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.state <= PS_RUN;
            q.sel   <= '0;
            q.hold  <= 1'b0;
            q.fpu   <= battery_insert_i;
            q.rc    <= 1'b0;
            q.wake  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_hit_w) begin
            rdata_o[SEL_W-1:0] = q.sel;
            rdata_o[BIT_HOLD]  = q.hold;
            rdata_o[BIT_FPU]   = q.fpu;
            rdata_o[BIT_SD]    = (q.state != PS_RUN);
        end
    end

    assign shutdown_req_o = (q.state != PS_RUN);
    assign rtc_clr_o      = q.rc;
    assign wake_o         = q.wake;

    sysclk_div_gen #(.SEL_W(SEL_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (!down_w),
        .sel_i  (q.sel),
        .en_o   (sys_clk_en_o)
    );

    sysclk_gpio_wake #(.GPIO_W(GPIO_W)) u_gw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .gpio_i     (gpio_i),
        .hold_i     (q.hold),
        .arm_i      ((q.state == PS_PEND) && q.hold),
        .clr_i      ((q.state == PS_RUN) || !q.hold),
        .down_i     (down_w),
        .gpio_o     (gpio_o),
        .wake_req_o (wake_req_w)
    );
endmodule

// File: rtl/sysclk_pwr_chk.sv
module sysclk_pwr_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hBE,
    parameter int                GPIO_W   = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        rdata_o,
    input logic              sys_clk_en_o,
    input logic              rtc_clr_o,
    input logic              shutdown_req_o,
    input logic              wake_o,
    input logic [GPIO_W-1:0] gpio_o,
    input logic              hold_q,
    input logic              down_q
);
    p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[6] == 1'b0) && (rdata_o[4] == 1'b0));

    p_rc_from_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rtc_clr_o |-> $past(wr_en_i && (addr_i == REG_ADDR) && wdata_i[4]));

    p_req_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && (addr_i == REG_ADDR) && wdata_i[7] && !down_q) |-> shutdown_req_o);

    p_no_en_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        down_q |-> (!sys_clk_en_o && shutdown_req_o));

    p_wake_from_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> ($past(down_q) && !down_q));

    p_hold_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_q && $past(hold_q)) |-> $stable(gpio_o));
endmodule

bind sysclk_pwr_ctrl sysclk_pwr_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .GPIO_W   (GPIO_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr_i),
    .wr_en_i        (wr_en_i),
    .wdata_i        (wdata_i),
    .rdata_o        (rdata_o),
    .sys_clk_en_o   (sys_clk_en_o),
    .rtc_clr_o      (rtc_clr_o),
    .shutdown_req_o (shutdown_req_o),
    .wake_o         (wake_o),
    .gpio_o         (gpio_o),
    .hold_q         (hold_w),
    .down_q         (down_w)
);

// File: tb/sim_sysclk_pwr_ctrl.sv
module sim_sysclk_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       en, rc, req, wake;
    logic       batt = 1'b0, done = 1'b0;
    logic [7:0] gin = 8'hFF;
    logic [7:0] gout;

    int nchk = 0, nfail = 0;
    int cyc = 0, last_en = 0, gap = 0;

    always #5 clk = ~clk;

    sysclk_pwr_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .sys_clk_en_o(en), .rtc_clr_o(rc),
        .battery_insert_i(batt), .shutdown_req_o(req), .shutdown_done_i(done),
        .wake_o(wake), .gpio_i(gin), .gpio_o(gout)
    );

    // spacing of clock-enable pulses, seen at each falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (en) begin
            gap     = cyc - last_en;
            last_en = cyc;
        end
    end

    typedef struct packed {
        logic [7:0] wr;
        logic [7:0] rd;
        logic [8:0] per;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 8'h00, 9'd1},
        '{8'h53, 8'h03, 9'd8},
        '{8'h07, 8'h07, 9'd128},
        '{8'h0A, 8'h0A, 9'd4},
        '{8'h01, 8'h01, 9'd2},
        '{8'h25, 8'h05, 9'd32},
        '{8'h06, 8'h06, 9'd64},
        '{8'h0C, 8'h0C, 9'd16}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] v);
        tick();
        addr = a; wdata = v; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] v);
        tick();
        addr = a; rd = 1'b1;
        #1 v = rdata;
        rd = 1'b0;
    endtask

    task automatic do_reset(input logic b);
        tick();
        rst_n = 1'b0; batt = b;
        repeat (4) tick();
        rst_n = 1'b1;
        batt = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       seen;

        // R1 reset state
        do_reset(1'b0);
        reg_rd(8'hBE, v);
        chk("R1 readback", v, 8'h00);
        repeat (3) tick();
        chk("R1 enable every cycle", gap, 1);
        chk("R1 no request", req, 0);
        chk("R1 no wake", wake, 0);

        // R2 R4 divider table
        for (int i = 0; i < 8; i++) begin
            reg_wr(8'hBE, VECS[i].wr);
            reg_rd(8'hBE, v);
            chk("R4 readback", v, VECS[i].rd);
            repeat (300) tick();
            chk("R2 enable period", gap, VECS[i].per);
        end

        // R3 no shortened period
        reg_wr(8'hBE, 8'h07);
        repeat (300) tick();
        do tick(); while (!en);
        repeat (3) tick();
        reg_wr(8'hBE, 8'h00);
        do tick(); while (!en);
        chk("R3 running period kept", gap, 128);
        tick();
        chk("R3 new period", gap, 1);

        // R5 rtc clear pulse
        reg_wr(8'hBE, 8'h10);
        chk("R5 pulse high", rc, 1);
        tick();
        chk("R5 pulse one cycle", rc, 0);
        reg_wr(8'hBE, 8'h00);
        chk("R5 no pulse on 0", rc, 0);

        // R13 other address
        reg_wr(8'hBD, 8'h05);
        reg_rd(8'hBE, v);
        chk("R13 register untouched", v, 8'h00);
        addr = 8'hBD; rd = 1'b1; #1;
        chk("R13 foreign read", rdata, 8'h00);
        rd = 1'b0;

        // R6 first power-up flag
        do_reset(1'b1);
        reg_rd(8'hBE, v);
        chk("R6 flag after battery reset", v, 8'h20);
        reg_wr(8'hBE, 8'h00);
        reg_rd(8'hBE, v);
        chk("R6 flag read-only", v, 8'h20);

        // R7 request and abort
        reg_wr(8'hBE, 8'h80);
        chk("R7 request raised", req, 1);
        reg_rd(8'hBE, v);
        chk("R7 bit7 reads 1", v, 8'hA0);
        reg_wr(8'hBE, 8'h00);
        chk("R7 abort", req, 0);

        // R10 GPIO hold
        gin = 8'hA5;
        reg_wr(8'hBE, 8'h08);
        gin = 8'h5A; #1;
        chk("R10 frozen", gout, 8'hA5);
        reg_wr(8'hBE, 8'h00);
        #1;
        chk("R10 follows", gout, 8'h5A);

        // R11 deferred edge with hold
        gin = 8'hFF;
        reg_wr(8'hBE, 8'h08);
        reg_wr(8'hBE, 8'h88);
        tick(); gin = 8'hFB;
        tick(); gin = 8'hFF;
        seen = 1'b0;
        repeat (5) begin tick(); seen = seen | wake; end
        chk("R11 no wake before done", seen, 0);
        done = 1'b1;
        tick(); done = 1'b0;
        chk("R8 enable low in shutdown", en, 0);
        chk("R8 request held", req, 1);
        tick();
        chk("R11 deferred wake", wake, 1);
        tick();
        chk("R9 wake one cycle", wake, 0);
        reg_rd(8'hBE, v);
        chk("R9 fields cleared", v, 8'h00);
        chk("R9 request released", req, 0);

        // R12 edge lost without hold, rising edge ignored
        reg_wr(8'hBE, 8'h80);
        tick(); gin = 8'hFE;
        tick();
        done = 1'b1;
        tick(); done = 1'b0;
        reg_wr(8'hBE, 8'h00);
        chk("R8 write ignored in shutdown", req, 1);
        gin = 8'hFF;
        seen = 1'b0;
        repeat (8) begin tick(); seen = seen | wake; end
        chk("R12 no wake from lost or rising edge", seen, 0);
        chk("R8 enable still low", en, 0);
        gin = 8'hDF;
        tick();
        chk("R9 wake on falling edge", wake, 1);
        repeat (3) tick();
        chk("R9 divide by one after wake", gap, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule